// File: doc/BRIEF.md
# Triggered Glitch Pulse Sequencer

This block plays a short, programmed list of output levels on one line, once, when an external trigger rises. Each list entry (a segment) gives an output level and a duration in clock ticks. Software fills the segment store, selects how many entries are used, and arms the engine. The next rising edge of the trigger starts playback. The entries play back to back, and the engine then falls back to a done state that needs a fresh arm. At a 100 MHz tick the duration field spans the multi-millisecond delays and the few-tick pulse widths that precise pulse placement needs.

After reset the store holds a three-entry program: a long low delay, a short high pulse, and a one-tick low tail. Software can play it straight away or overwrite it. The trigger passes through a two-stage synchronizer. Those two ticks of latency are taken out of the first segment, so every segment boundary falls at a fixed offset from the first clock edge that samples the trigger high.

A second output drives a relay that holds a target in reset. A command raises it for a programmed hold time. It is then released, and a programmed settle time runs before the relay reports ready again. A small word-addressed register port carries all loading, commands and status reads. Reads are combinational.

Top module: `glitch_seq_top`

## Requirements
- R1: After reset, glitch_out and relay_out are 0 and status reads 0. The segment store holds a default program, read back at 0x8 + i with level in bit 31 and duration in bits DUR_W-1:0: entry 0 = low for DEF_DELAY, entry 1 = high for DEF_PULSE, entry 2 = low for 1. The count register (address 0x1) reads 3.
- R2: A trigger rising edge that arrives while the engine is not armed leaves glitch_out low and sets a sticky overrun flag (status bit 2). The flag is cleared only by writing 1 to control bit 2 (address 0x0).
- R3: Let E0 be the first clock edge at which trig_in is sampled high. Segment i drives its level from edge E0 + (sum of the durations of segments 0 to i-1). Segment 0 starts at E0+2, so its visible length is its duration minus 2, and never less than 1.
- R4: After the last selected segment ends, glitch_out is 0 and the status state field reads 3 (done). A further trigger starts nothing and sets overrun.
- R5: Only the first COUNT entries are played. A count write above N_SEG is stored, and read back, as N_SEG.
- R6: A segment with zero duration ends the sequence at that point. The engine goes to done with glitch_out low.
- R7: Writing 1 to control bit 1 (disarm) in any state takes effect at the same clock edge. glitch_out is driven low and the state field reads 0 (idle).
- R8: Writing 1 to control bit 0 (arm) moves the engine from idle or done to armed. Status bits 1:0 encode idle=0, armed=1, running=2 and done=3. An arm write while armed or running has no effect.
- R9: Writing 1 to control bit 3 while the relay is ready raises relay_out for HOLD ticks (address 0x3; 0 acts as 1). relay_out then drops and SETTLE more ticks (address 0x4) follow. Status bit 3 stays 1 from the command edge until settle ends. A command while bit 3 is set is ignored.
- R10: The default program, armed and triggered, leaves glitch_out low until edge E0+DEF_DELAY, drives it high for DEF_PULSE ticks, and then holds it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Asynchronous active-high trigger |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| glitch_out | output | 1 | Sequenced pulse output |
| relay_out | output | 1 | Timed reset-relay drive |

## Verification
The bench builds the block with N_SEG=4, DUR_W=12, RLY_W=8, DEF_DELAY=40 and DEF_PULSE=5. The default program then completes in tens of ticks instead of hundreds of thousands, and the count clamp is reached with a write of 9. The small store lets a full-length list, an early zero-duration end and a truncated count all be played within a short run. A behavioural model built on absolute cycle numbers is compared with both outputs on every clock.

// File: rtl/gseq_pkg.sv
`timescale 1ns/1ps
package gseq_pkg;

    localparam int SYNC_STAGES = 2;
    localparam int MAX_SEG     = 8;

    localparam logic [3:0] A_CTRL    = 4'h0;
    localparam logic [3:0] A_COUNT   = 4'h1;
    localparam logic [3:0] A_STATUS  = 4'h2;
    localparam logic [3:0] A_RHOLD   = 4'h3;
    localparam logic [3:0] A_RSETTLE = 4'h4;
    localparam logic [3:0] A_SEG0    = 4'h8;

    localparam int B_ARM    = 0;
    localparam int B_DISARM = 1;
    localparam int B_CLR    = 2;
    localparam int B_RELAY  = 3;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_ARMED = 2'd1,
        PS_RUN   = 2'd2,
        PS_DONE  = 2'd3
    } play_st_e;

    typedef enum logic [1:0] {
        RL_IDLE   = 2'd0,
        RL_HOLD   = 2'd1,
        RL_SETTLE = 2'd2
    } relay_st_e;

    typedef struct packed {
        logic relay_go;
        logic clr_ovr;
        logic disarm;
        logic arm;
    } cmd_t;

    typedef struct packed {
        logic     relay_busy;
        logic     overrun;
        play_st_e state;
    } status_t;

    function automatic cmd_t decode_ctrl(input logic we, input logic [3:0] addr,
                                         input logic [31:0] d);
        cmd_t c;
        logic hit;
        hit        = we && (addr == A_CTRL);
        c.arm      = hit && d[B_ARM];
        c.disarm   = hit && d[B_DISARM];
        c.clr_ovr  = hit && d[B_CLR];
        c.relay_go = hit && d[B_RELAY];
        return c;
    endfunction

endpackage

// File: rtl/gseq_regs.sv
`timescale 1ns/1ps
module gseq_regs
    import gseq_pkg::*;
#(
    parameter int N_SEG     = 8,
    parameter int DUR_W     = 24,
    parameter int RLY_W     = 24,
    parameter int DEF_DELAY = 230000,
    parameter int DEF_PULSE = 16,
    parameter int CNT_W     = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [3:0]                  addr,
    input  logic [31:0]                 wdata,
    output logic [N_SEG-1:0]            seg_lvl,
    output logic [N_SEG-1:0][DUR_W-1:0] seg_dur,
    output logic [CNT_W-1:0]            seg_count,
    output logic [RLY_W-1:0]            rly_hold,
    output logic [RLY_W-1:0]            rly_settle,
    output cmd_t                        cmd
);

    localparam logic [CNT_W-1:0] RST_COUNT = CNT_W'(3);

    assign cmd = decode_ctrl(we, addr, wdata);

    for (genvar i = 0; i < N_SEG; i++) begin : g_seg
        localparam logic [DUR_W-1:0] RST_DUR =
            (i == 0) ? DUR_W'(DEF_DELAY) :
            (i == 1) ? DUR_W'(DEF_PULSE) :
            (i == 2) ? DUR_W'(1) : '0;
        localparam logic RST_LVL = (i == 1);

        logic             hit;
        logic             lvl_q;
        logic [DUR_W-1:0] dur_q;

        assign hit = we && (addr == (A_SEG0 + 4'(i)));

        always_ff @(posedge clk) begin
            if (rst) begin
                lvl_q <= RST_LVL;
                dur_q <= RST_DUR;
            end else if (hit) begin
                lvl_q <= wdata[31];
                dur_q <= wdata[DUR_W-1:0];
            end
        end

        assign seg_lvl[i] = lvl_q;
        assign seg_dur[i] = dur_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_count  <= RST_COUNT;
            rly_hold   <= '0;
            rly_settle <= '0;
        end else if (we) begin
            case (addr)
                A_COUNT: begin
                    if (wdata > 32'(N_SEG)) seg_count <= CNT_W'(N_SEG);
                    else                    seg_count <= wdata[CNT_W-1:0];
                end
                A_RHOLD:   rly_hold   <= wdata[RLY_W-1:0];
                A_RSETTLE: rly_settle <= wdata[RLY_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gseq_sync.sv
`timescale 1ns/1ps
module gseq_sync
    import gseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= async_in;
    end

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[s] <= 1'b0;
            else     chain_q[s] <= chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[SYNC_STAGES-1];
    end

    assign rise = chain_q[SYNC_STAGES-1] && !last_q;

endmodule

// File: rtl/gseq_player.sv
`timescale 1ns/1ps
module gseq_player
    import gseq_pkg::*;
#(
    parameter int N_SEG = 8,
    parameter int DUR_W = 24,
    parameter int CNT_W = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rise,
    input  cmd_t                        cmd,
    input  logic [N_SEG-1:0]            seg_lvl,
    input  logic [N_SEG-1:0][DUR_W-1:0] seg_dur,
    input  logic [CNT_W-1:0]            seg_count,
    output logic                        pulse_q,
    output play_st_e                    state_q,
    output logic                        ovr_q
);

    localparam logic [DUR_W-1:0] LAT = DUR_W'(SYNC_STAGES);

    logic [CNT_W-1:0] idx_q;
    logic [DUR_W-1:0] rem_q;

    logic [CNT_W-1:0] nxt_idx;
    logic [DUR_W-1:0] nxt_dur;
    logic             nxt_lvl;
    logic             nxt_ok;
    logic             first_ok;
    logic [DUR_W-1:0] lead_len;

    always_comb begin
        nxt_idx = idx_q + 1'b1;
        nxt_dur = '0;
        nxt_lvl = 1'b0;
        for (int i = 0; i < N_SEG; i++) begin
            if (CNT_W'(i) == nxt_idx) begin
                nxt_dur = seg_dur[i];
                nxt_lvl = seg_lvl[i];
            end
        end
        nxt_ok   = (nxt_idx < seg_count) && (nxt_dur != '0);
        first_ok = (seg_count != '0) && (seg_dur[0] != '0);
        lead_len = (seg_dur[0] > LAT) ? (seg_dur[0] - LAT) : DUR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q <= 1'b0;
        end else if (rise && (state_q != PS_ARMED)) begin
            ovr_q <= 1'b1;
        end else if (cmd.clr_ovr) begin
            ovr_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_IDLE;
            pulse_q <= 1'b0;
            idx_q   <= '0;
            rem_q   <= '0;
        end else if (cmd.disarm) begin
            state_q <= PS_IDLE;
            pulse_q <= 1'b0;
        end else begin
            case (state_q)
                PS_IDLE, PS_DONE: begin
                    if (cmd.arm) state_q <= PS_ARMED;
                end
                PS_ARMED: begin
                    if (rise) begin
                        if (first_ok) begin
                            state_q <= PS_RUN;
                            idx_q   <= '0;
                            rem_q   <= lead_len;
                            pulse_q <= seg_lvl[0];
                        end else begin
                            state_q <= PS_DONE;
                            pulse_q <= 1'b0;
                        end
                    end
                end
                PS_RUN: begin
                    if (rem_q == DUR_W'(1)) begin
                        if (nxt_ok) begin
                            idx_q   <= nxt_idx;
                            rem_q   <= nxt_dur;
                            pulse_q <= nxt_lvl;
                        end else begin
                            state_q <= PS_DONE;
                            pulse_q <= 1'b0;
                        end
                    end else begin
                        rem_q <= rem_q - 1'b1;
                    end
                end
                default: state_q <= PS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/gseq_relay.sv
`timescale 1ns/1ps
module gseq_relay
    import gseq_pkg::*;
#(
    parameter int RLY_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [RLY_W-1:0] hold,
    input  logic [RLY_W-1:0] settle,
    output logic             relay_q,
    output logic             busy
);

    relay_st_e        st_q;
    logic [RLY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= RL_IDLE;
            cnt_q   <= '0;
            relay_q <= 1'b0;
        end else begin
            case (st_q)
                RL_IDLE: begin
                    if (go) begin
                        st_q    <= RL_HOLD;
                        cnt_q   <= (hold == '0) ? RLY_W'(1) : hold;
                        relay_q <= 1'b1;
                    end
                end
                RL_HOLD: begin
                    if (cnt_q == RLY_W'(1)) begin
                        relay_q <= 1'b0;
                        if (settle == '0) begin
                            st_q <= RL_IDLE;
                        end else begin
                            st_q  <= RL_SETTLE;
                            cnt_q <= settle;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                RL_SETTLE: begin
                    if (cnt_q == RLY_W'(1)) st_q <= RL_IDLE;
                    else                    cnt_q <= cnt_q - 1'b1;
                end
                default: begin
                    st_q    <= RL_IDLE;
                    relay_q <= 1'b0;
                end
            endcase
        end
    end

    assign busy = (st_q != RL_IDLE);

endmodule

// File: rtl/glitch_seq_top.sv
`timescale 1ns/1ps
module glitch_seq_top
    import gseq_pkg::*;
#(
    parameter int N_SEG     = 8,
    parameter int DUR_W     = 24,
    parameter int RLY_W     = 24,
    parameter int DEF_DELAY = 230000,
    parameter int DEF_PULSE = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        trig_in,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        glitch_out,
    output logic        relay_out
);

    localparam int CNT_W = $clog2(N_SEG + 1);

    logic [N_SEG-1:0]            seg_lvl;
    logic [N_SEG-1:0][DUR_W-1:0] seg_dur;
    logic [CNT_W-1:0]            seg_count;
    logic [RLY_W-1:0]            rly_hold;
    logic [RLY_W-1:0]            rly_settle;
    cmd_t                        cmd;
    logic                        trig_rise;
    play_st_e                    play_st;
    logic                        ovr_flag;
    logic                        rly_busy;
    status_t                     status;

    gseq_regs #(
        .N_SEG(N_SEG), .DUR_W(DUR_W), .RLY_W(RLY_W),
        .DEF_DELAY(DEF_DELAY), .DEF_PULSE(DEF_PULSE), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .seg_lvl(seg_lvl), .seg_dur(seg_dur), .seg_count(seg_count),
        .rly_hold(rly_hold), .rly_settle(rly_settle), .cmd(cmd)
    );

    gseq_sync u_sync (
        .clk(clk), .rst(rst), .async_in(trig_in), .rise(trig_rise)
    );

    gseq_player #(
        .N_SEG(N_SEG), .DUR_W(DUR_W), .CNT_W(CNT_W)
    ) u_player (
        .clk(clk), .rst(rst), .rise(trig_rise), .cmd(cmd),
        .seg_lvl(seg_lvl), .seg_dur(seg_dur), .seg_count(seg_count),
        .pulse_q(glitch_out), .state_q(play_st), .ovr_q(ovr_flag)
    );

    gseq_relay #(
        .RLY_W(RLY_W)
    ) u_relay (
        .clk(clk), .rst(rst), .go(cmd.relay_go), .hold(rly_hold),
        .settle(rly_settle), .relay_q(relay_out), .busy(rly_busy)
    );

    assign status = '{relay_busy: rly_busy, overrun: ovr_flag, state: play_st};

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_COUNT:   reg_rdata[CNT_W-1:0] = seg_count;
            A_STATUS:  reg_rdata[3:0]       = status;
            A_RHOLD:   reg_rdata[RLY_W-1:0] = rly_hold;
            A_RSETTLE: reg_rdata[RLY_W-1:0] = rly_settle;
            default: begin
                for (int i = 0; i < N_SEG; i++) begin
                    if (reg_addr == (A_SEG0 + 4'(i))) begin
                        reg_rdata[31]        = seg_lvl[i];
                        reg_rdata[DUR_W-1:0] = seg_dur[i];
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/gseq_chk.sv
`timescale 1ns/1ps
module gseq_chk
    import gseq_pkg::*;
#(
    parameter int N_SEG = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             glitch_out,
    input logic             relay_out,
    input logic             rly_busy,
    input logic [1:0]       st,
    input logic             ovr,
    input logic [CNT_W-1:0] cnt,
    input logic             reg_we,
    input logic [3:0]       reg_addr,
    input logic [31:0]      reg_wdata
);

    logic ctrl_wr;
    assign ctrl_wr = reg_we && (reg_addr == A_CTRL);

    assert_out_low_unless_running_R4: assert property (@(posedge clk) disable iff (rst)
        (st != 2'd2) |-> !glitch_out);

    assert_disarm_aborts_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && reg_wdata[B_DISARM]) |=> (st == 2'd0) && !glitch_out);

    assert_overrun_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        (ovr && !(ctrl_wr && reg_wdata[B_CLR])) |=> ovr);

    assert_run_only_from_armed_R8: assert property (@(posedge clk) disable iff (rst)
        (st != 2'd1 && st != 2'd2) |=> (st != 2'd2));

    assert_relay_low_when_ready_R9: assert property (@(posedge clk) disable iff (rst)
        !rly_busy |-> !relay_out);

    assert_count_clamped_R5: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(N_SEG));

endmodule

bind glitch_seq_top gseq_chk #(.N_SEG(N_SEG), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .glitch_out(glitch_out), .relay_out(relay_out),
    .rly_busy(rly_busy), .st(play_st), .ovr(ovr_flag), .cnt(seg_count),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/glitch_seq_top_tb.sv
`timescale 1ns/1ps
module glitch_seq_top_tb;

    localparam int N_SEG = 4;
    localparam int DUR_W = 12;
    localparam int RLY_W = 8;
    localparam int DEF_DELAY = 40;
    localparam int DEF_PULSE = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig_in = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        glitch_out;
    logic        relay_out;

    glitch_seq_top #(
        .N_SEG(N_SEG), .DUR_W(DUR_W), .RLY_W(RLY_W),
        .DEF_DELAY(DEF_DELAY), .DEF_PULSE(DEF_PULSE)
    ) u_dut (
        .clk(clk), .rst(rst), .trig_in(trig_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .glitch_out(glitch_out), .relay_out(relay_out)
    );

    always #2.5 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int cyc = 0;
    int m_st, m_idx, m_end, m_cnt, m_rh, m_rs;
    bit m_out, m_ovr, m_rly, trig_prev;
    int m_lvl[N_SEG];
    int m_dur[N_SEG];
    int rise_q[$];
    int r_start = -100, r_hold_end = -100, r_settle_end = -100;

    always @(posedge clk) begin
        bit rise_now, c_arm, c_dis, c_clr, c_go;
        cyc++;
        if (rst) begin
            m_st = 0; m_out = 0; m_ovr = 0; m_idx = 0; m_end = 0; m_cnt = 3;
            m_rh = 0; m_rs = 0; trig_prev = 0; rise_q.delete();
            for (int i = 0; i < N_SEG; i++) begin m_lvl[i] = 0; m_dur[i] = 0; end
            m_dur[0] = DEF_DELAY; m_lvl[1] = 1; m_dur[1] = DEF_PULSE; m_dur[2] = 1;
            r_start = -100; r_hold_end = -100; r_settle_end = -100; m_rly = 0;
        end else begin
            rise_now = 0;
            if (rise_q.size() > 0 && rise_q[0] == cyc) begin
                rise_now = 1;
                void'(rise_q.pop_front());
            end
            if (trig_in && !trig_prev) rise_q.push_back(cyc + 2);
            trig_prev = trig_in;
            c_arm = reg_we && reg_addr == 4'h0 && reg_wdata[0];
            c_dis = reg_we && reg_addr == 4'h0 && reg_wdata[1];
            c_clr = reg_we && reg_addr == 4'h0 && reg_wdata[2];
            c_go  = reg_we && reg_addr == 4'h0 && reg_wdata[3];
            if (rise_now && m_st != 1) m_ovr = 1;
            else if (c_clr) m_ovr = 0;
            if (c_dis) begin
                m_st = 0; m_out = 0;
            end else begin
                case (m_st)
                    0, 3: if (c_arm) m_st = 1;
                    1: if (rise_now) begin
                        if (m_cnt > 0 && m_dur[0] > 0) begin
                            m_st = 2; m_idx = 0; m_out = m_lvl[0][0];
                            m_end = cyc + ((m_dur[0] > 2) ? m_dur[0] - 2 : 1);
                        end else begin
                            m_st = 3; m_out = 0;
                        end
                    end
                    2: if (cyc == m_end) begin
                        if (m_idx + 1 < m_cnt && m_dur[m_idx + 1] > 0) begin
                            m_idx++; m_end = cyc + m_dur[m_idx]; m_out = m_lvl[m_idx][0];
                        end else begin
                            m_st = 3; m_out = 0;
                        end
                    end
                    default: ;
                endcase
            end
            if (c_go && cyc >= r_settle_end) begin
                r_start = cyc;
                r_hold_end = cyc + ((m_rh == 0) ? 1 : m_rh);
                r_settle_end = r_hold_end + m_rs;
            end
            m_rly = (cyc >= r_start && cyc < r_hold_end);
            if (reg_we) begin
                if (reg_addr == 4'h1) m_cnt = (reg_wdata > N_SEG) ? N_SEG : int'(reg_wdata);
                else if (reg_addr == 4'h3) m_rh = int'(reg_wdata[RLY_W-1:0]);
                else if (reg_addr == 4'h4) m_rs = int'(reg_wdata[RLY_W-1:0]);
                else if (reg_addr >= 4'h8 && reg_addr < 4'h8 + N_SEG) begin
                    m_lvl[reg_addr - 4'h8] = int'(reg_wdata[31]);
                    m_dur[reg_addr - 4'h8] = int'(reg_wdata[DUR_W-1:0]);
                end
            end
        end
    end

    // every-cycle comparison and pulse measurement
    int hi_cnt = 0, first_hi = -1, rl_cnt = 0;
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(glitch_out === m_out, "R3 glitch_out vs model", int'(glitch_out), int'(m_out));
            check(relay_out === m_rly, "R9 relay_out vs model", int'(relay_out), int'(m_rly));
            if (glitch_out === 1'b1) begin
                if (first_hi < 0) first_hi = cyc;
                hi_cnt++;
            end
            if (relay_out === 1'b1) rl_cnt++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic fire(output int e0);
        @(negedge clk);
        trig_in = 1'b1;
        e0 = cyc + 1;
        repeat (3) @(negedge clk);
        trig_in = 1'b0;
    endtask

    task automatic clear_meas();
        @(negedge clk);
        hi_cnt = 0; first_hi = -1; rl_cnt = 0;
    endtask

    function automatic logic [31:0] seg(input bit lvl, input int d);
        return {lvl, 19'd0, 12'(d)};
    endfunction

    initial begin
        #600000;
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int e0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state and default program
        rd(4'h2, d); check(d == 0, "R1 status after reset", int'(d), 0);
        check(glitch_out == 0 && relay_out == 0, "R1 outputs low", int'({glitch_out, relay_out}), 0);
        rd(4'h8, d); check(d == seg(0, DEF_DELAY), "R1 entry0", int'(d), int'(seg(0, DEF_DELAY)));
        rd(4'h9, d); check(d == seg(1, DEF_PULSE), "R1 entry1", int'(d), int'(seg(1, DEF_PULSE)));
        rd(4'hA, d); check(d == seg(0, 1), "R1 entry2", int'(d), int'(seg(0, 1)));
        rd(4'h1, d); check(d == 3, "R1 count", int'(d), 3);

        // R2 trigger while idle
        clear_meas();
        fire(e0); repeat (10) @(negedge clk);
        check(hi_cnt == 0, "R2 no pulse while idle", hi_cnt, 0);
        rd(4'h2, d); check(d[2] == 1, "R2 overrun set", int'(d[2]), 1);
        repeat (5) @(negedge clk);
        rd(4'h2, d); check(d[2] == 1, "R2 overrun sticky", int'(d[2]), 1);
        wr(4'h0, 32'h4);
        rd(4'h2, d); check(d[2] == 0, "R2 overrun cleared", int'(d[2]), 0);

        // R8 arm, R10 default program
        wr(4'h0, 32'h1);
        rd(4'h2, d); check(d[1:0] == 1, "R8 armed code", int'(d[1:0]), 1);
        clear_meas();
        fire(e0);
        repeat (20) @(negedge clk);
        rd(4'h2, d); check(d[1:0] == 2, "R8 running code", int'(d[1:0]), 2);
        repeat (40) @(negedge clk);
        check(first_hi == e0 + DEF_DELAY, "R10 pulse start", first_hi, e0 + DEF_DELAY);
        check(hi_cnt == DEF_PULSE, "R10 pulse width", hi_cnt, DEF_PULSE);
        rd(4'h2, d); check(d[1:0] == 3, "R4 done code", int'(d[1:0]), 3);
        check(d[2] == 0, "R2 no overrun on armed trigger", int'(d[2]), 0);

        // R4 one shot
        clear_meas();
        fire(e0); repeat (20) @(negedge clk);
        check(hi_cnt == 0, "R4 second trigger ignored", hi_cnt, 0);
        rd(4'h2, d); check(d[2] == 1 && d[1:0] == 3, "R4 overrun after done", int'(d[3:0]), 7);
        wr(4'h0, 32'h4);

        // R3 custom list, high first segment
        wr(4'h8, seg(1, 6)); wr(4'h9, seg(0, 3)); wr(4'hA, seg(1, 2)); wr(4'hB, seg(0, 4));
        wr(4'h1, 32'd9);
        rd(4'h1, d); check(d == N_SEG, "R5 count clamp", int'(d), N_SEG);
        wr(4'h0, 32'h1);
        clear_meas();
        fire(e0); repeat (25) @(negedge clk);
        check(first_hi == e0 + 2, "R3 first segment after sync latency", first_hi, e0 + 2);
        check(hi_cnt == 6, "R3 high ticks full list", hi_cnt, 6);

        // R5 truncated count
        wr(4'h1, 32'd2); wr(4'h0, 32'h1);
        clear_meas();
        fire(e0); repeat (20) @(negedge clk);
        check(hi_cnt == 4, "R5 only first two entries", hi_cnt, 4);

        // R6 zero-length entry
        wr(4'h1, 32'd4); wr(4'h9, seg(0, 0)); wr(4'h0, 32'h1);
        clear_meas();
        fire(e0); repeat (12) @(negedge clk);
        check(hi_cnt == 4, "R6 stop at zero entry", hi_cnt, 4);
        rd(4'h2, d); check(d[1:0] == 3, "R6 done", int'(d[1:0]), 3);

        // R7 abort, R8 arm ignored while running
        wr(4'h8, seg(0, 20)); wr(4'h9, seg(1, 40)); wr(4'h1, 32'd2); wr(4'h0, 32'h1);
        fire(e0);
        wait (glitch_out == 1'b1);
        repeat (3) @(negedge clk);
        wr(4'h0, 32'h1);
        rd(4'h2, d); check(d[1:0] == 2, "R8 arm ignored while running", int'(d[1:0]), 2);
        check(glitch_out == 1, "R8 output continues", int'(glitch_out), 1);
        wr(4'h0, 32'h2);
        check(glitch_out == 0, "R7 output low after disarm", int'(glitch_out), 0);
        rd(4'h2, d); check(d[1:0] == 0, "R7 idle after disarm", int'(d[1:0]), 0);

        // R9 relay
        wr(4'h3, 32'd5); wr(4'h4, 32'd4);
        clear_meas();
        wr(4'h0, 32'h8);
        rd(4'h2, d); check(d[3] == 1, "R9 busy during hold", int'(d[3]), 1);
        repeat (4) @(negedge clk);
        wr(4'h0, 32'h8);
        repeat (6) @(negedge clk);
        check(rl_cnt == 5, "R9 hold length, busy command ignored", rl_cnt, 5);
        rd(4'h2, d); check(d[3] == 0, "R9 ready after settle", int'(d[3]), 0);
        wr(4'h3, 32'd0);
        clear_meas();
        wr(4'h0, 32'h8);
        repeat (8) @(negedge clk);
        check(rl_cnt == 1, "R9 zero hold acts as one", rl_cnt, 1);

        repeat (5) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule